// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every data beat of an SDRAM read or write burst. When a column command arrives it captures a 9-bit start column, a 2-bit bank, the direction and an auto-precharge flag. From the next cycle on it presents one column per clock until the configured burst has been covered. Finite bursts of 1, 2, 4 or 8 beats wrap inside an aligned block of their own length. A full-page burst walks all 512 columns and comes back round to the start, and keeps going until a burst-stop request arrives.

A single-write mode cuts every write down to the addressed column alone. A new column command in the middle of a burst abandons the old burst and restarts from the new address. When a finite burst or a single write finishes, a done strobe is raised for one cycle. If auto-precharge was requested, a precharge request for the burst's bank is raised in that same cycle. The read output enable follows the read beats only, so the data bus is released as soon as a read finishes. Command decoding, the CAS-latency delay of data and the storage array belong to other blocks.

Top module: `sdram_burst_colgen`

## Requirements
- R1: Out of reset, beat_valid_o, rd_oe_o, done_o and pre_req_o are all low.
- R2: When cmd_valid is high at a clock edge, in the following cycle beat_valid_o is high, col_o equals the captured cmd_col and bank_o equals the captured cmd_bank.
- R3: The burst length code cfg_blen selects the number of beats: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. After the last beat, beat_valid_o goes low and done_o is high for exactly one cycle.
- R4: In a finite burst of length L, the column bits above log2(L) stay at the start value. The low log2(L) bits count up by one per beat and wrap to zero, so start 6 with length 4 gives 6, 7, 4, 5.
- R5: Code 7 selects a full page. The column then advances by one per beat modulo 512, comes back to the start column after 512 beats and continues with no end of its own.
- R6: A high bst during a full-page burst ends it. In the next cycle beat_valid_o is low and done_o is high, and pre_req_o stays low.
- R7: bst has no effect on a finite burst or while idle. The beat count, the columns and done_o are all unchanged.
- R8: With cfg_single_wr high, a write command makes exactly one beat whatever the length code. Reads keep the configured length.
- R9: With cmd_autopre set on a finite burst or a single write, pre_req_o is high in the same cycle as done_o, and bank_o still shows that burst's bank. A full-page burst never raises pre_req_o.
- R10: rd_oe_o is high exactly in the cycles where beat_valid_o is high for a read, and it is low for writes and when idle.
- R11: A command that arrives during an active burst reloads the generator from the new start column in the next cycle. The interrupted burst gives no done_o and no pre_req_o.
- R12: Length codes 4, 5 and 6 behave as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Column command strobe (read or write) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_autopre | input | 1 | Request precharge when the access completes |
| cmd_col | input | 9 | Start column |
| cmd_bank | input | 2 | Bank select |
| cfg_blen | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| cfg_single_wr | input | 1 | Writes access a single column |
| bst | input | 1 | Burst stop request |
| col_o | output | 9 | Column of the current beat |
| bank_o | output | 2 | Bank of the current or last burst |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_write_o | output | 1 | Direction of the current burst |
| rd_oe_o | output | 1 | Read data output enable |
| done_o | output | 1 | One-cycle pulse after a burst completes |
| pre_req_o | output | 1 | Auto-precharge request for bank_o |

## Verification
Finite bursts are driven with start columns that sit in the middle of their aligned block. This separates true block wrapping from plain incrementing, and it also catches wrong beat counts. A full-page burst is started near the top of the column range and run past 512 beats, which shows both the rollover at 511 and the return to the start column before burst stop ends it. Burst stop is also applied during a finite burst and while idle, where nothing may change. Writes are run with and without single-write mode, auto-precharge is run against plain bursts, and a mid-burst reload is tried. Together these show whether the done and precharge strobes belong to the right burst.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef enum logic [2:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_PAGE = 3'd7
    } blen_e;

    localparam int MAX_FIN_LOG = 3;

endpackage

// File: rtl/colgen_len_dec.sv
module colgen_len_dec
    import colgen_pkg::*;
#(
    parameter int COL_W = 9,
    parameter int CNT_W = MAX_FIN_LOG
) (
    input  logic [2:0]       blen,
    input  logic             single,
    output logic [COL_W-1:0] mask,
    output logic [CNT_W-1:0] cnt_init,
    output logic             full
);
    always_comb begin
        mask     = '0;
        cnt_init = '0;
        full     = 1'b0;
        if (!single) begin
            case (blen_e'(blen))
                BLEN_2: begin
                    mask     = COL_W'(1);
                    cnt_init = CNT_W'(1);
                end
                BLEN_4: begin
                    mask     = COL_W'(3);
                    cnt_init = CNT_W'(3);
                end
                BLEN_8: begin
                    mask     = COL_W'(7);
                    cnt_init = CNT_W'(7);
                end
                BLEN_PAGE: begin
                    mask = '1;
                    full = 1'b1;
                end
                default: begin
                    mask     = '0;
                    cnt_init = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/colgen_next_col.sv
module colgen_next_col #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] col,
    input  logic [COL_W-1:0] mask,
    output logic [COL_W-1:0] nxt
);
    logic [COL_W-1:0] inc;
    assign inc = col + COL_W'(1);

    genvar i;
    for (i = 0; i < COL_W; i++) begin : g_bit
        assign nxt[i] = mask[i] ? inc[i] : col[i];
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic              cmd_autopre,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [2:0]        cfg_blen,
    input  logic              cfg_single_wr,
    input  logic              bst,
    output logic [COL_W-1:0]  col_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              beat_valid_o,
    output logic              beat_write_o,
    output logic              rd_oe_o,
    output logic              done_o,
    output logic              pre_req_o
);
    localparam int CNT_W = MAX_FIN_LOG;

    typedef struct packed {
        logic              active;
        logic              write;
        logic              autopre;
        logic              full;
        logic [COL_W-1:0]  col;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  mask;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              pre;
    } state_t;

    state_t s_d, s_q;

    logic [COL_W-1:0] new_mask_d;
    logic [CNT_W-1:0] new_cnt_d;
    logic             new_full_d;
    logic [COL_W-1:0] step_col_d;

    colgen_len_dec #(.COL_W(COL_W), .CNT_W(CNT_W)) u_len (
        .blen     (cfg_blen),
        .single   (cmd_write & cfg_single_wr),
        .mask     (new_mask_d),
        .cnt_init (new_cnt_d),
        .full     (new_full_d)
    );

    colgen_next_col #(.COL_W(COL_W)) u_step (
        .col  (s_q.col),
        .mask (s_q.mask),
        .nxt  (step_col_d)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.pre  = 1'b0;
        if (cmd_valid) begin
            s_d.active  = 1'b1;
            s_d.write   = cmd_write;
            s_d.autopre = cmd_autopre & ~new_full_d;
            s_d.full    = new_full_d;
            s_d.col     = cmd_col;
            s_d.bank    = cmd_bank;
            s_d.mask    = new_mask_d;
            s_d.cnt     = new_cnt_d;
        end else if (s_q.active) begin
            if (s_q.full) begin
                if (bst) begin
                    s_d.active = 1'b0;
                    s_d.done   = 1'b1;
                end else begin
                    s_d.col = step_col_d;
                end
            end else if (s_q.cnt == '0) begin
                s_d.active = 1'b0;
                s_d.done   = 1'b1;
                s_d.pre    = s_q.autopre;
            end else begin
                s_d.col = step_col_d;
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign col_o        = s_q.col;
    assign bank_o       = s_q.bank;
    assign beat_valid_o = s_q.active;
    assign beat_write_o = s_q.write;
    assign rd_oe_o      = s_q.active & ~s_q.write;
    assign done_o       = s_q.done;
    assign pre_req_o    = s_q.pre;

    // R2: a command shows up as a valid beat at its start column
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (beat_valid_o && col_o == $past(cmd_col) && bank_o == $past(cmd_bank)));

    // R3: done is a single-cycle pulse with no beat alongside it
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!beat_valid_o) ##1 !done_o);

    // R4: in a finite burst, bits outside the block never move
    a_r4_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && !s_q.full && !cmd_valid && s_q.cnt != '0)
        |=> (beat_valid_o && ((col_o & ~s_q.mask) == ($past(col_o) & ~s_q.mask))));

    // R5: a full page advances by one modulo the column range
    a_r5_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && s_q.full && !bst && !cmd_valid)
        |=> (beat_valid_o && col_o == COL_W'($past(col_o) + 1'b1)));

    // R6: burst stop in a full page ends it without a precharge
    a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && s_q.full && bst && !cmd_valid)
        |=> (!beat_valid_o && done_o && !pre_req_o));

    // R9: a precharge request only comes with completion
    a_r9_pre_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req_o |-> done_o);

    // R10: the read enable only appears during a beat
    a_r10_oe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe_o |-> (beat_valid_o && !beat_write_o));

    // R11: a reload during a burst gives no completion strobe
    a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && beat_valid_o) |=> (!done_o && !pre_req_o));
endmodule

// File: tb/sdram_burst_colgen_test.sv
`timescale 1ns/1ps
module sdram_burst_colgen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic       cmd_autopre = 1'b0;
    logic [8:0] cmd_col = '0;
    logic [1:0] cmd_bank = '0;
    logic [2:0] cfg_blen = '0;
    logic       cfg_single_wr = 1'b0;
    logic       bst = 1'b0;
    logic [8:0] col_o;
    logic [1:0] bank_o;
    logic       beat_valid_o, beat_write_o, rd_oe_o, done_o, pre_req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    sdram_burst_colgen uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_autopre(cmd_autopre), .cmd_col(cmd_col), .cmd_bank(cmd_bank),
        .cfg_blen(cfg_blen), .cfg_single_wr(cfg_single_wr), .bst(bst),
        .col_o(col_o), .bank_o(bank_o), .beat_valid_o(beat_valid_o),
        .beat_write_o(beat_write_o), .rd_oe_o(rd_oe_o), .done_o(done_o),
        .pre_req_o(pre_req_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic int len_of(input int code, input bit w, input bit sw);
        if (w && sw) return 1;
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 512;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int start, input int len, input int k);
        if (len == 512) return (start + k) % 512;
        return (start & ~(len - 1)) | ((start + k) & (len - 1));
    endfunction

    task automatic issue(input bit w, input bit ap, input int col, input int bank,
                         input int code, input bit sw);
        cmd_write = w; cmd_autopre = ap; cmd_col = 9'(col); cmd_bank = 2'(bank);
        cfg_blen = 3'(code); cfg_single_wr = sw; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // runs a finite burst; stop_at >= 0 pulses bst at that beat (R7)
    task automatic finite_burst(input string req, input bit w, input bit ap, input int col,
                                input int bank, input int code, input bit sw, input int stop_at);
        int len;
        len = len_of(code, w, sw);
        @(negedge clk);
        issue(w, ap, col, bank, code, sw);
        for (int k = 0; k < len; k++) begin
            chk(beat_valid_o, {req, " beat valid"}, beat_valid_o, 1);
            chk(col_o == 9'(exp_col(col, len, k)), {req, " column"}, col_o, exp_col(col, len, k));
            chk(bank_o == 2'(bank), {req, " R2 bank"}, bank_o, bank);
            chk(rd_oe_o == (!w), {req, " R10 read enable"}, rd_oe_o, !w);
            chk(!done_o, {req, " R3 no early done"}, done_o, 0);
            bst = (k == stop_at);
            @(negedge clk);
            bst = 1'b0;
        end
        chk(!beat_valid_o, {req, " R3 ended"}, beat_valid_o, 0);
        chk(done_o, {req, " R3 done"}, done_o, 1);
        chk(pre_req_o == ap, {req, " R9 precharge"}, pre_req_o, ap);
        chk(bank_o == 2'(bank), {req, " R9 precharge bank"}, bank_o, bank);
        chk(!rd_oe_o, {req, " R10 released"}, rd_oe_o, 0);
        @(negedge clk);
        chk(!done_o && !pre_req_o, {req, " R3 done one cycle"}, done_o, 0);
    endtask

    task automatic t_reset();
        chk(!beat_valid_o, "R1 valid", beat_valid_o, 0);
        chk(!rd_oe_o, "R1 oe", rd_oe_o, 0);
        chk(!done_o, "R1 done", done_o, 0);
        chk(!pre_req_o, "R1 pre", pre_req_o, 0);
    endtask

    task automatic t_lengths();
        finite_burst("R3 len1", 1'b0, 1'b0, 37, 1, 0, 1'b0, -1);
        finite_burst("R3 len2", 1'b0, 1'b0, 37, 2, 1, 1'b0, -1);
        finite_burst("R4 len4", 1'b0, 1'b0, 6, 3, 2, 1'b0, -1);
        finite_burst("R4 len8", 1'b1, 1'b0, 205, 0, 3, 1'b0, -1);
        finite_burst("R12 code5", 1'b0, 1'b0, 99, 1, 5, 1'b0, -1);
        finite_burst("R12 code6", 1'b1, 1'b0, 12, 2, 6, 1'b0, -1);
    endtask

    task automatic t_single_write();
        finite_burst("R8 single write", 1'b1, 1'b0, 77, 2, 3, 1'b1, -1);
        finite_burst("R8 read unaffected", 1'b0, 1'b0, 77, 2, 3, 1'b1, -1);
    endtask

    task automatic t_autopre();
        finite_burst("R9 read ap", 1'b0, 1'b1, 130, 3, 2, 1'b0, -1);
        finite_burst("R9 single write ap", 1'b1, 1'b1, 400, 1, 7, 1'b1, -1);
    endtask

    task automatic t_bst_ignored();
        finite_burst("R7 bst finite", 1'b0, 1'b0, 3, 1, 3, 1'b0, 2);
        @(negedge clk);
        bst = 1'b1;
        @(negedge clk);
        bst = 1'b0;
        chk(!beat_valid_o && !done_o, "R7 bst idle", beat_valid_o, 0);
    endtask

    task automatic t_full_page();
        @(negedge clk);
        issue(1'b0, 1'b1, 500, 2, 7, 1'b0);
        for (int k = 0; k < 520; k++) begin
            if (!beat_valid_o || col_o != 9'((500 + k) % 512))
                chk(1'b0, "R5 page column", col_o, (500 + k) % 512);
            if (!rd_oe_o) chk(1'b0, "R10 page oe", rd_oe_o, 1);
            if (k == 512) chk(col_o == 9'd500, "R5 back to start", col_o, 500);
            if (k == 519) bst = 1'b1;
            @(negedge clk);
        end
        bst = 1'b0;
        chk(1'b1, "R5 page run", 0, 0);
        chk(!beat_valid_o, "R6 stopped", beat_valid_o, 0);
        chk(done_o, "R6 done", done_o, 1);
        chk(!pre_req_o, "R6 R9 no precharge", pre_req_o, 0);
    endtask

    task automatic t_reload();
        @(negedge clk);
        issue(1'b0, 1'b1, 16, 0, 3, 1'b0);
        for (int k = 0; k < 3; k++) @(negedge clk);
        chk(col_o == 9'd19, "R11 before reload", col_o, 19);
        issue(1'b1, 1'b0, 101, 3, 2, 1'b0);
        for (int k = 0; k < 4; k++) begin
            chk(beat_valid_o && col_o == 9'(exp_col(101, 4, k)), "R11 new column",
                col_o, exp_col(101, 4, k));
            chk(!done_o && !pre_req_o, "R11 no done", done_o, 0);
            chk(bank_o == 2'd3 && beat_write_o, "R11 new bank", bank_o, 3);
            @(negedge clk);
        end
        chk(done_o && !pre_req_o && !beat_valid_o, "R11 new burst done", done_o, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lengths();
        t_single_write();
        t_autopre();
        t_bst_ignored();
        t_full_page();
        t_reload();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule